// File: doc/BRIEF.md
# Differential Current Window Sampler

This block collects one analysis window of differential-current samples for a transformer protection relay. An external square-wave strobe sets the sampling pace. Each low phase of the strobe triggers exactly one conversion request to an analog-to-digital converter. The block then waits for the converter's completion flag and takes in the unsigned result.

The analog front end adds a fixed level shift so that the converter only ever sees a unipolar signal. The block subtracts that shift, which gives a signed sample. It writes the sample into the next slot of a window buffer and folds the sample's magnitude into a running peak. After the last slot is written, the block raises a one-cycle flag. The downstream harmonic logic reads the whole buffer and the peak in that cycle. The block then carries on with the next strobe low phase and starts a fresh window.

The block re-arms only after it has seen the strobe high again, so one low phase can never produce two samples. The strobe is synchronised by two flops before it is used.

Top module: `diff_sample_window`

## Requirements
- R1: After reset, `adc_start_o` is 0, `win_valid_o` is 0 and `win_peak_o` is 0.
- R2: At most one conversion is requested per strobe low phase. Arming needs the strobe to have been seen high since reset or since the previous request, so a strobe held low from reset requests nothing.
- R3: `adc_start_o` is a pulse that lasts a single clock cycle.
- R4: Each stored sample equals the converter code minus OFFSET (default 1638, which is 2 V of a 5 V, 12-bit range), as a 13-bit two's complement value.
- R5: The window holds N_SAMP (13) samples in arrival order. Sample k of the window sits at `win_data_o[k*13 +: 13]`, and k = 0 is the first sample.
- R6: When `win_valid_o` is high, `win_peak_o` equals the largest absolute value of the samples in that window. The peak restarts from the first sample of each window.
- R7: `win_valid_o` goes high for exactly one clock in the cycle after the 13th sample of a window is accepted, and at no other time.
- R8: An `adc_done_i` pulse that arrives while no conversion is outstanding is ignored. It changes neither the buffer nor the peak.
- R9: After a window completes, sampling continues with the next strobe low phase, which fills slot 0 of a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | External sampling strobe, active low phase |
| adc_start_o | output | 1 | One-cycle conversion request |
| adc_done_i | input | 1 | Conversion complete, data valid |
| adc_data_i | input | 12 | Unsigned converter result |
| win_valid_o | output | 1 | One-cycle flag: window complete |
| win_data_o | output | 169 | Flattened window of 13 signed 13-bit samples |
| win_peak_o | output | 13 | Largest sample magnitude of the window |

## Verification
The bench holds the strobe low for many cycles after each sample is taken. A design without proper re-arming would issue a second request in that time, and the per-phase request count would expose it. It also holds the strobe low straight out of reset, where a design that armed at reset would sample early.

The extreme codes 0 and 4095 and the codes around the offset are applied. A wrong offset sign or a wrong rectification would then show up as a wrong sample value or a wrong peak.

A stray completion pulse is injected while the block is idle. If that pulse were accepted, the window contents would shift and the extra 4095 code would raise the peak. A window made entirely of zero-valued samples is also run. Its peak must drop back to 0, which catches a peak register that is not cleared between windows.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [0:0] {
    CONV_IDLE = 1'b0,
    CONV_WAIT = 1'b1
  } conv_state_t;
endpackage

// File: rtl/dsw_strobe_arm.sv
module dsw_strobe_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic launch_i,
  output logic strobe_low_o,
  output logic armed_o
);
  logic meta_q, sync_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      sync_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      meta_q <= strobe_i;
      sync_q <= meta_q;
      if (launch_i)    armed_q <= 1'b0;
      else if (sync_q) armed_q <= 1'b1;
    end
  end

  assign strobe_low_o = ~sync_q;
  assign armed_o      = armed_q;
endmodule

// File: rtl/dsw_sample_cond.sv
module dsw_sample_cond #(
  parameter int ADC_W  = 12,
  parameter int OFFSET = 1638,
  localparam int SW    = ADC_W + 1
) (
  input  logic [ADC_W-1:0]     code_i,
  output logic signed [SW-1:0] samp_o,
  output logic [SW-1:0]        mag_o
);
  localparam logic signed [SW-1:0] OFS_S = SW'(OFFSET);

  function automatic logic signed [SW-1:0] strip_shift(input logic [ADC_W-1:0] c);
    return $signed({1'b0, c}) - OFS_S;
  endfunction

  function automatic logic [SW-1:0] rectify(input logic signed [SW-1:0] s);
    return s[SW-1] ? SW'(-s) : SW'(s);
  endfunction

  assign samp_o = strip_shift(code_i);
  assign mag_o  = rectify(samp_o);
endmodule

// File: rtl/dsw_window_store.sv
module dsw_window_store #(
  parameter int SW     = 13,
  parameter int N_SAMP = 13,
  localparam int CW    = $clog2(N_SAMP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_i,
  input  logic signed [SW-1:0] samp_i,
  input  logic [SW-1:0]        mag_i,
  output logic [N_SAMP*SW-1:0] data_o,
  output logic [SW-1:0]        peak_o,
  output logic                 full_o
);
  localparam logic [CW-1:0] LAST = CW'(N_SAMP - 1);

  logic [CW-1:0] idx_q;
  logic [SW-1:0] peak_q;
  logic          full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      peak_q <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= take_i && (idx_q == LAST);
      if (take_i) begin
        idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        if (idx_q == '0)          peak_q <= mag_i;
        else if (mag_i > peak_q)  peak_q <= mag_i;
      end
    end
  end

  for (genvar g = 0; g < N_SAMP; g++) begin : g_slot
    logic [SW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            slot_q <= '0;
      else if (take_i && idx_q == CW'(g))    slot_q <= samp_i;
    end
    assign data_o[g*SW +: SW] = slot_q;
  end

  assign peak_o = peak_q;
  assign full_o = full_q;
endmodule

// File: rtl/diff_sample_window.sv
module diff_sample_window #(
  parameter int ADC_W  = 12,
  parameter int N_SAMP = 13,
  parameter int OFFSET = 1638,
  localparam int SW    = ADC_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe_i,
  output logic                 adc_start_o,
  input  logic                 adc_done_i,
  input  logic [ADC_W-1:0]     adc_data_i,
  output logic                 win_valid_o,
  output logic [N_SAMP*SW-1:0] win_data_o,
  output logic [SW-1:0]        win_peak_o
);
  import dsw_pkg::*;

  conv_state_t state_q;
  logic        start_q;
  logic        strobe_low_w, armed_w, fire_w, busy_w, sample_take;
  logic signed [SW-1:0] samp_w;
  logic [SW-1:0]        mag_w;

  assign busy_w      = (state_q == CONV_WAIT);
  assign fire_w      = (state_q == CONV_IDLE) && armed_w && strobe_low_w;
  assign sample_take = busy_w && adc_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CONV_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= fire_w;
      if (fire_w)           state_q <= CONV_WAIT;
      else if (sample_take) state_q <= CONV_IDLE;
    end
  end

  assign adc_start_o = start_q;

  dsw_strobe_arm u_arm (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_i     (strobe_i),
    .launch_i     (fire_w),
    .strobe_low_o (strobe_low_w),
    .armed_o      (armed_w)
  );

  dsw_sample_cond #(.ADC_W(ADC_W), .OFFSET(OFFSET)) u_cond (
    .code_i (adc_data_i),
    .samp_o (samp_w),
    .mag_o  (mag_w)
  );

  dsw_window_store #(.SW(SW), .N_SAMP(N_SAMP)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (sample_take),
    .samp_i (samp_w),
    .mag_i  (mag_w),
    .data_o (win_data_o),
    .peak_o (win_peak_o),
    .full_o (win_valid_o)
  );
endmodule

// File: rtl/dsw_checker.sv
module dsw_checker #(
  parameter int SW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_start_o,
  input logic          adc_done_i,
  input logic          win_valid_o,
  input logic [SW-1:0] win_peak_o,
  input logic          busy_w,
  input logic          armed_w,
  input logic          sample_take,
  input logic [SW-1:0] mag_w
);
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o);

  a_r2_start_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |-> (busy_w && !armed_w));

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |=> !win_valid_o);

  a_r7_valid_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> $past(sample_take));

  a_r6_peak_covers: assert property (@(posedge clk) disable iff (!rst_n)
    sample_take |=> (win_peak_o >= $past(mag_w)));

  a_r8_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done_i && !busy_w) |=> $stable(win_peak_o));
endmodule

bind diff_sample_window dsw_checker #(.SW(SW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adc_start_o (adc_start_o),
  .adc_done_i  (adc_done_i),
  .win_valid_o (win_valid_o),
  .win_peak_o  (win_peak_o),
  .busy_w      (busy_w),
  .armed_w     (armed_w),
  .sample_take (sample_take),
  .mag_w       (mag_w)
);

// File: tb/diff_sample_window_tb_top.sv
module diff_sample_window_tb_top;
  localparam int ADC_W = 12;
  localparam int NS    = 13;
  localparam int SW    = 13;
  localparam int OFS   = 1638;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic done = 1'b0;
  logic [ADC_W-1:0] data = '0;
  logic start, valid;
  logic [NS*SW-1:0] wdata;
  logic [SW-1:0] wpeak;

  int n_cmp = 0, n_bad = 0;
  int start_cnt = 0, valid_cnt = 0, cyc = 0;
  logic prev_valid = 1'b0;
  logic [NS*SW-1:0] cap_data;
  logic [SW-1:0] cap_peak;
  int exp_q[$];

  always #5 clk = ~clk;

  diff_sample_window dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe),
    .adc_start_o(start), .adc_done_i(done), .adc_data_i(data),
    .win_valid_o(valid), .win_data_o(wdata), .win_peak_o(wpeak)
  );

  function automatic int exp_sample(input int code);
    return code - OFS;
  endfunction

  function automatic int magn(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (start) start_cnt++;
    if (valid) begin
      valid_cnt++;
      cap_data = wdata;
      cap_peak = wpeak;
      if (prev_valid) check("R7 valid width", 2, 1);
    end
    prev_valid = valid;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog got=%0d exp=0", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one strobe low phase: expect exactly one request, answer it with code
  task automatic phase(input int code);
    int s0, w;
    s0 = start_cnt;
    strobe = 1'b0;
    w = 0;
    while (!start && w < 30) begin @(negedge clk); w++; end
    idle(2);
    done = 1'b1; data = ADC_W'(code);
    @(negedge clk);
    done = 1'b0;
    exp_q.push_back(exp_sample(code));
    idle(8);
    check("R2 one request per low phase", start_cnt - s0, 1);
    strobe = 1'b1;
    idle(4);
  endtask

  task automatic check_window();
    int pk, v0;
    pk = 0;
    v0 = valid_cnt;
    check("R7 one valid per window", (v0 > 0) ? 1 : 0, 1);
    for (int k = 0; k < NS; k++) begin
      int e;
      e = exp_q.pop_front();
      if (magn(e) > pk) pk = magn(e);
      check($sformatf("R4/R5 slot %0d", k), int'($signed(cap_data[k*SW +: SW])), e);
    end
    check("R6 window peak", int'(cap_peak), pk);
  endtask

  initial begin
    int vbase, pk_before;
    void'($urandom(32'd20240611));
    idle(3);
    check("R1 start idle", int'(start), 0);
    check("R1 valid idle", int'(valid), 0);
    check("R1 peak zero", int'(wpeak), 0);
    rst_n = 1'b1;
    // strobe low from reset: must not sample before a high phase
    idle(12);
    check("R2 no request before high seen", start_cnt, 0);
    strobe = 1'b1;
    idle(4);

    // window 0: directed extremes
    vbase = valid_cnt;
    phase(0); phase(4095); phase(OFS); phase(OFS - 1); phase(OFS + 1);
    for (int i = 0; i < 8; i++) phase(int'($urandom_range(4095, 0)));
    check("R7 valid count w0", valid_cnt - vbase, 1);
    check_window();

    // window 1: random, continues right after previous (R9)
    vbase = valid_cnt;
    for (int i = 0; i < NS; i++) phase(int'($urandom_range(2500, 800)));
    check("R9 next window completes", valid_cnt - vbase, 1);
    check_window();

    // window 2: stray done pulses while idle (R8)
    vbase = valid_cnt;
    for (int i = 0; i < NS; i++) begin
      phase(int'($urandom_range(1800, 1500)));
      if (i == 4 || i == 12) begin
        pk_before = int'(wpeak);
        done = 1'b1; data = 12'hFFF;
        @(negedge clk);
        done = 1'b0;
        idle(2);
        check("R8 stray done leaves peak", int'(wpeak), pk_before);
      end
    end
    check("R8 window count unchanged by stray", valid_cnt - vbase, 1);
    check_window();

    // window 3: all zero samples -> peak must restart at 0
    vbase = valid_cnt;
    for (int i = 0; i < NS; i++) phase(OFS);
    check("R7 valid count w3", valid_cnt - vbase, 1);
    check_window();
    check("R3 requests equal samples", start_cnt, 4 * NS);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule